// File: doc/BRIEF.md
# Gamma-Corrected LED Breathing Sequencer

This block makes one LED appear to breathe. It walks an index up through a perceptual brightness curve and then back down, and it emits the matching 8-bit duty byte once per step. Two fixed curves are built in: a 32-point curve suited to a breath of about one second, and a 64-point curve suited to a breath of about two seconds. The duty byte and its one-cycle update strobe can feed a PWM channel directly, or they can tell a bus master when to write the new byte to an LED driver's duty register.

A programmable prescaler sets the time between steps. With a table of N points and a divider value D, one full breath lasts (2N − 2)·(D + 1) clock cycles, so software picks D from the wanted period and the curve length. Dropping `enable` blanks the output and rewinds the walk. A new curve choice is picked up only when the walk sits at the dark end.

Top module: `breath_gamma_seq`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `duty` is 0 and `dutyStrobe` is 0.
- R2: With the short curve selected (`tableSel` = 0), index i maps to the duty value i of the 32-point curve 0, 1, 2, 4, 6, 10, 13, 18, 22, 28, 33, 39, 46, 53, 61, 69, 78, 86, 96, 106, 116, 126, 138, 149, 161, 173, 186, 199, 212, 226, 240, 255.
- R3: With the long curve selected (`tableSel` = 1), index i maps to the duty value i of the 64-point curve, which rises from 0, 1, 2, 3 through 8, 10, 12 and 26, 29, 32 up to 223, 230, 237, 244, 251, 255.
- R4: While enabled, the index climbs 0, 1, …, N−1 and then falls N−2, …, 0 and climbs again. Neither end value is issued twice in a row, so one breath takes 2N − 2 steps.
- R5: Successive steps are exactly `stepDiv` + 1 clock cycles apart. The first strobe after `enable` rises comes `stepDiv` + 2 cycles after the first rising edge at which `enable` is sampled high.
- R6: Each step raises `dutyStrobe` for one cycle, and `duty` shows the new value in that same cycle. `duty` does not change in any cycle without a strobe while enabled.
- R7: One cycle after `enable` is sampled low, `duty` is 0 and `dutyStrobe` is 0. They stay 0 while disabled, and the next enable restarts the walk at index 0 going upward.
- R8: A change of `tableSel` made while the index is not 0 has no effect until the index returns to 0. The curve in force from then on is the one selected when the walk leaves index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the breathing walk when high; blank and rewind when low |
| tableSel | input | 1 | Curve choice: 0 = 32-point, 1 = 64-point |
| stepDiv | input | DIV_W | Prescaler count; step interval is stepDiv + 1 cycles |
| duty | output | 8 | Current duty byte |
| dutyStrobe | output | 1 | One-cycle pulse when duty takes a new step value |

## Verification
The bench builds the sequencer with a 6-bit divider and uses divider values from 0 to 7. At these values a full 126-step breath on the long curve fits in about a thousand cycles, so both turnarounds and both curves are covered many times. A divider of 0 makes the strobe fire every cycle, which is the back-to-back boundary. The other values test the interval counting. Curve changes are made at random points in mid-breath to test the rule that the choice is held until the walk reaches index 0.

// File: rtl/breath_pkg.sv
package breath_pkg;

  localparam int SHORT_STEPS = 32;
  localparam int LONG_STEPS  = 64;
  localparam int IDX_W       = $clog2(LONG_STEPS);
  localparam int SHORT_W     = $clog2(SHORT_STEPS);

  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_STEPS - 1);
  localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_STEPS - 1);

  // Strobes from the walk control into the duty datapath.
  typedef struct packed {
    logic step;   // index moved this cycle
    logic clear;  // walk disabled: blank the output
  } seqStrobe_t;

  localparam logic [7:0] CURVE_SHORT [SHORT_STEPS] = '{
    8'd0,   8'd1,   8'd2,   8'd4,   8'd6,   8'd10,  8'd13,  8'd18,
    8'd22,  8'd28,  8'd33,  8'd39,  8'd46,  8'd53,  8'd61,  8'd69,
    8'd78,  8'd86,  8'd96,  8'd106, 8'd116, 8'd126, 8'd138, 8'd149,
    8'd161, 8'd173, 8'd186, 8'd199, 8'd212, 8'd226, 8'd240, 8'd255
  };

  localparam logic [7:0] CURVE_LONG [LONG_STEPS] = '{
    8'd0,   8'd1,   8'd2,   8'd3,   8'd4,   8'd5,   8'd6,   8'd7,
    8'd8,   8'd10,  8'd12,  8'd14,  8'd16,  8'd18,  8'd20,  8'd22,
    8'd24,  8'd26,  8'd29,  8'd32,  8'd35,  8'd38,  8'd41,  8'd44,
    8'd47,  8'd50,  8'd53,  8'd57,  8'd61,  8'd65,  8'd69,  8'd73,
    8'd77,  8'd81,  8'd85,  8'd89,  8'd94,  8'd99,  8'd104, 8'd109,
    8'd114, 8'd119, 8'd124, 8'd129, 8'd134, 8'd140, 8'd146, 8'd152,
    8'd158, 8'd164, 8'd170, 8'd176, 8'd182, 8'd188, 8'd195, 8'd202,
    8'd209, 8'd216, 8'd223, 8'd230, 8'd237, 8'd244, 8'd251, 8'd255
  };

  function automatic logic [7:0] gammaLevel(input logic longCurve,
                                            input logic [IDX_W-1:0] idx);
    if (longCurve) return CURVE_LONG[idx];
    return CURVE_SHORT[idx[SHORT_W-1:0]];
  endfunction

endpackage

// File: rtl/breath_ctrl.sv
module breath_ctrl
  import breath_pkg::*;
#(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             tableSel,
  input  logic [DIV_W-1:0] stepDiv,
  output seqStrobe_t       strobes,
  output logic [IDX_W-1:0] idx,
  output logic             activeSel
);

  logic [DIV_W-1:0] tickCnt;
  logic             dirUp;
  logic             stepped;
  logic             expire;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] nextIdx;
  logic             nextUp;

  assign expire  = enable && (tickCnt >= stepDiv);
  assign lastIdx = activeSel ? LONG_LAST : SHORT_LAST;

  // Bounce between the two ends without repeating either end point.
  always_comb begin
    nextIdx = idx;
    nextUp  = dirUp;
    if (dirUp) begin
      if (idx == lastIdx) begin
        nextIdx = idx - 1'b1;
        nextUp  = 1'b0;
      end else begin
        nextIdx = idx + 1'b1;
      end
    end else begin
      if (idx == '0) begin
        nextIdx = IDX_W'(1);
        nextUp  = 1'b1;
      end else begin
        nextIdx = idx - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt   <= '0;
      idx       <= '0;
      dirUp     <= 1'b1;
      stepped   <= 1'b0;
      activeSel <= 1'b0;
    end else begin
      // Curve choice is only sampled while resting at the dark end.
      if (idx == '0) activeSel <= tableSel;
      if (!enable) begin
        tickCnt <= '0;
        idx     <= '0;
        dirUp   <= 1'b1;
        stepped <= 1'b0;
      end else begin
        stepped <= expire;
        if (expire) begin
          tickCnt <= '0;
          idx     <= nextIdx;
          dirUp   <= nextUp;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end
  end

  assign strobes.step  = stepped;
  assign strobes.clear = !enable;

  p_idx_in_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    idx <= lastIdx);

  p_unit_move_r4: assert property (@(posedge clk) disable iff (!rstN)
    stepped |-> (idx == IDX_W'($past(idx) + 1'b1)) || (idx == IDX_W'($past(idx) - 1'b1)));

  p_top_turn_r4: assert property (@(posedge clk) disable iff (!rstN)
    (expire && dirUp && idx == lastIdx) |=> (!dirUp && idx == IDX_W'(lastIdx - 1'b1)));

  p_sel_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (idx != '0) |=> $stable(activeSel));

endmodule

// File: rtl/breath_duty.sv
module breath_duty
  import breath_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobes,
  input  logic [IDX_W-1:0] idx,
  input  logic             activeSel,
  output logic [7:0]       duty,
  output logic             dutyStrobe
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      duty       <= '0;
      dutyStrobe <= 1'b0;
    end else if (strobes.clear) begin
      duty       <= '0;
      dutyStrobe <= 1'b0;
    end else begin
      dutyStrobe <= strobes.step;
      if (strobes.step) duty <= gammaLevel(activeSel, idx);
    end
  end

  p_blank_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (duty == '0 && !dutyStrobe));

  p_duty_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.step && !strobes.clear) |=> $stable(duty));

endmodule

// File: rtl/breath_gamma_seq.sv
module breath_gamma_seq
  import breath_pkg::*;
#(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             tableSel,
  input  logic [DIV_W-1:0] stepDiv,
  output logic [7:0]       duty,
  output logic             dutyStrobe
);

  seqStrobe_t       strobes;
  logic [IDX_W-1:0] idx;
  logic             activeSel;

  breath_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .tableSel  (tableSel),
    .stepDiv   (stepDiv),
    .strobes   (strobes),
    .idx       (idx),
    .activeSel (activeSel)
  );

  breath_duty u_duty (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .idx        (idx),
    .activeSel  (activeSel),
    .duty       (duty),
    .dutyStrobe (dutyStrobe)
  );

  p_step_to_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && enable) |=> dutyStrobe);

endmodule

// File: tb/breath_gamma_seq_bench.sv
module breath_gamma_seq_bench;
  localparam int DIV_W = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             tableSel = 1'b0;
  logic [DIV_W-1:0] stepDiv = '0;
  logic [7:0]       duty;
  logic             dutyStrobe;

  int checks = 0;
  int fails  = 0;

  // Walk model
  int  mIdx;
  bit  mUp;
  bit  mSel;
  bit  pendingFlip;
  bit  freshStart;
  int  lastDuty;

  always #10 clk = ~clk;

  breath_gamma_seq #(.DIV_W(DIV_W)) u_breath_gamma_seq (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .tableSel   (tableSel),
    .stepDiv    (stepDiv),
    .duty       (duty),
    .dutyStrobe (dutyStrobe)
  );

  int shortCurve [32] = '{0, 1, 2, 4, 6, 10, 13, 18, 22, 28, 33, 39, 46, 53, 61, 69,
                          78, 86, 96, 106, 116, 126, 138, 149, 161, 173, 186, 199, 212, 226, 240, 255};
  int longCurve [64] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 10, 12, 14, 16, 18, 20, 22,
                         24, 26, 29, 32, 35, 38, 41, 44, 47, 50, 53, 57, 61, 65, 69, 73,
                         77, 81, 85, 89, 94, 99, 104, 109, 114, 119, 124, 129, 134, 140, 146, 152,
                         158, 164, 170, 176, 182, 188, 195, 202, 209, 216, 223, 230, 237, 244, 251, 255};

  function automatic int expLevel(input bit sel, input int i);
    return sel ? longCurve[i] : shortCurve[i];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic startRun(input bit sel, input int div);
    @(negedge clk);
    tableSel    = sel;
    stepDiv     = DIV_W'(div);
    enable      = 1'b1;
    mIdx        = 0;
    mUp         = 1'b1;
    mSel        = sel;
    pendingFlip = 1'b0;
    freshStart  = 1'b1;
    lastDuty    = 0;
  endtask

  task automatic watch(input int nSteps, input bit flip);
    int got = 0;
    int gap = 0;
    while (got < nSteps) begin
      @(negedge clk);
      gap++;
      if (dutyStrobe) begin
        int n;
        int expGap;
        bit turn;
        string tag;
        if (mIdx == 0) begin
          mSel        = tableSel;
          pendingFlip = 1'b0;
        end
        n    = mSel ? 64 : 32;
        turn = 1'b0;
        if (mUp) begin
          if (mIdx == n - 1) begin mUp = 1'b0; mIdx--; turn = 1'b1; end
          else mIdx++;
        end else begin
          if (mIdx == 0) begin mUp = 1'b1; mIdx = 1; turn = 1'b1; end
          else mIdx--;
        end
        expGap = freshStart ? int'(stepDiv) + 2 : int'(stepDiv) + 1;
        check(gap == expGap, "R5 step interval", gap, expGap);
        if (pendingFlip)     tag = "R8 curve held";
        else if (freshStart) tag = "R7 restart at index 0";
        else if (turn)       tag = "R4 turnaround";
        else if (mSel)       tag = "R3 long curve";
        else                 tag = "R2 short curve";
        check(int'(duty) == expLevel(mSel, mIdx), tag, int'(duty), expLevel(mSel, mIdx));
        lastDuty   = int'(duty);
        freshStart = 1'b0;
        gap        = 0;
        got++;
        if (flip && !pendingFlip && mIdx >= 2 && $urandom_range(0, 9) == 0) begin
          tableSel    = ~tableSel;
          pendingFlip = (tableSel != mSel);
        end
      end else begin
        check(int'(duty) == lastDuty, "R6 duty held between strobes", int'(duty), lastDuty);
      end
    end
  endtask

  task automatic stopRun();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(duty == 8'd0, "R7 duty blanked", int'(duty), 0);
    check(dutyStrobe == 1'b0, "R7 strobe low", int'(dutyStrobe), 0);
    repeat (3) @(negedge clk);
    check(duty == 8'd0 && !dutyStrobe, "R7 stays blank", int'(duty), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(duty == 8'd0, "R1 reset duty", int'(duty), 0);
    check(dutyStrobe == 1'b0, "R1 reset strobe", int'(dutyStrobe), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(duty == 8'd0 && !dutyStrobe, "R1 after reset", int'(duty), 0);

    // Directed: short curve, fastest stepping, two full breaths.
    startRun(1'b0, 0);
    watch(130, 1'b0);
    stopRun();

    // Directed: long curve, divider 3, more than one breath.
    startRun(1'b1, 3);
    watch(140, 1'b0);
    stopRun();

    // Directed R8: switch to the long curve in mid-ascent on the short one.
    startRun(1'b0, 2);
    watch(20, 1'b0);
    tableSel    = 1'b1;
    pendingFlip = 1'b1;
    watch(110, 1'b0);
    stopRun();

    // Random runs with mid-breath curve changes.
    for (int r = 0; r < 8; r++) begin
      startRun(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)));
      watch(int'($urandom_range(20, 160)), 1'b1);
      stopRun();
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule